// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches a set of already-synchronized general-purpose pins, grouped into banks of equal width, and turns selected pin conditions into one interrupt line. Each pin has its own sensitivity setting. It can fire on a level, either high or low. It can fire on one edge, rising or falling. It can also fire on any change. A detected condition is latched into a per-pin sticky status bit. The interrupt output is asserted while any latched bit is also unmasked.

Software reaches the block through a simple single-cycle register bus. Masking only gates propagation: detection and latching go on for masked pins. Before unmasking a pin, software should therefore clear its status bit, or it should expect an immediate interrupt. The mask cannot be written directly. It is set through a write-one "disable" register and cleared through a write-one "enable" register, and it can be read back.

Top module: `gpio_irq_top`

## Requirements
- R1: While reset is held, every mask bit reads 1, every status bit reads 0, the type, polarity and any-edge registers read 0, and `irq_o` is low.
- R2: Word address = bank * 8 + index. Index 0 is the type register (1 = edge, 0 = level), index 1 is polarity (1 = rising/high, 0 = falling/low), and index 2 is any-edge. All three are read/write, and a write to one bank leaves the other banks unchanged.
- R3: Writing to the enable register (index 3) clears every mask bit where the data is 1 and leaves the others unchanged. A write to the mask register (index 5) has no effect.
- R4: Writing to the disable register (index 4) sets every mask bit where the data is 1 and leaves the others unchanged. The mask register reads at index 5.
- R5: For an edge pin whose any-edge bit is 0, the status bit sets on the clock edge where the sampled pin differs from its previous sample in the direction chosen by polarity. It does not set for the opposite edge.
- R6: For an edge pin whose any-edge bit is 1, both directions set the status bit and the polarity bit is ignored.
- R7: For a level pin, the status bit sets on every clock where the pin equals its polarity bit, and the any-edge bit is ignored. Clearing the bit while the level persists leaves it set.
- R8: The status register (index 6) clears each bit written with 1. Bits written with 0 keep their value.
- R9: Status bits latch while the pin is masked, and `irq_o` rises right after an enable write unmasks a pin with a latched bit.
- R10: `irq_o` is high exactly when some bank has a bit that is set in status and clear in mask, in any bank.
- R11: Reads of the enable, disable and reserved (index 7) registers return 0. Accesses to a bank number at or beyond the bank count write nothing and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | BANK_AW+3 | Word address: bank number above a 3-bit register index |
| bus_wdata | input | BANK_W | Write data |
| bus_rdata | output | BANK_W | Combinational read data for `bus_addr` |
| pin_i | input | NUM_BANKS*BANK_W | Synchronized pin levels, bank 0 in the low bits |
| irq_o | output | 1 | Combined interrupt, high while any unmasked status bit is set |

## Verification
A wrong detection term or a lost previous-sample bit shows up as a status bit that reads wrong one clock after the pin is driven. A wrong mask update shows up on the very next read of the mask register, and also through `irq_o` in the same cycle the status bit is set. Status that is lost or latched spuriously shows up in `irq_o` as soon as the affected pin is unmasked. The sweep covers every pin of a small configuration, each of the five sensitivity settings, and all four pin transitions. Any single faulty bit in any bank is therefore seen within a few cycles of its stimulus.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int REG_IDX_W = 3;

    typedef enum logic [REG_IDX_W-1:0] {
        IDX_KIND   = 3'd0,
        IDX_SENSE  = 3'd1,
        IDX_BOTH   = 3'd2,
        IDX_UNMASK = 3'd3,
        IDX_SETMSK = 3'd4,
        IDX_MASK   = 3'd5,
        IDX_STATUS = 3'd6,
        IDX_RSVD   = 3'd7
    } reg_idx_e;

endpackage

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  reg_idx_e     wr_idx,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] kind_o,
    output logic [W-1:0] sense_o,
    output logic [W-1:0] both_o,
    output logic [W-1:0] mask_o,
    output logic [W-1:0] stat_o,
    output logic         pend_o
);

    typedef struct packed {
        logic [W-1:0] kind;
        logic [W-1:0] sense;
        logic [W-1:0] both;
        logic [W-1:0] mask;
        logic [W-1:0] stat;
        logic [W-1:0] prev;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic [W-1:0] rise_w, fall_w, edge_hit_w, lvl_hit_w, det_w, clr_w;

    always_comb begin
        rise_w     = pin_i & ~st_q.prev;
        fall_w     = ~pin_i & st_q.prev;
        edge_hit_w = (st_q.both & (rise_w | fall_w))
                   | (~st_q.both & st_q.sense & rise_w)
                   | (~st_q.both & ~st_q.sense & fall_w);
        lvl_hit_w  = ~(pin_i ^ st_q.sense);
        det_w      = (st_q.kind & edge_hit_w) | (~st_q.kind & lvl_hit_w);

        st_d      = st_q;
        st_d.prev = pin_i;
        clr_w     = '0;
        if (wr_en) begin
            case (wr_idx)
                IDX_KIND:   st_d.kind  = wr_data;
                IDX_SENSE:  st_d.sense = wr_data;
                IDX_BOTH:   st_d.both  = wr_data;
                IDX_UNMASK: st_d.mask  = st_q.mask & ~wr_data;
                IDX_SETMSK: st_d.mask  = st_q.mask | wr_data;
                IDX_STATUS: clr_w      = wr_data;
                default:    ;
            endcase
        end
        st_d.stat = (st_q.stat & ~clr_w) | det_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.kind  <= '0;
            st_q.sense <= '0;
            st_q.both  <= '0;
            st_q.mask  <= '1;
            st_q.stat  <= '0;
            st_q.prev  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign kind_o  = st_q.kind;
    assign sense_o = st_q.sense;
    assign both_o  = st_q.both;
    assign mask_o  = st_q.mask;
    assign stat_o  = st_q.stat;
    assign pend_o  = |(st_q.stat & ~st_q.mask);

    a_r1_reset_state: assert property (@(posedge clk)
        $rose(rst_n) |-> ((&st_q.mask) && (st_q.stat == '0)));

    a_r4_mask_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (wr_idx == IDX_UNMASK || wr_idx == IDX_SETMSK)) |=> $stable(st_q.mask));

    a_r3_unmask_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IDX_UNMASK) |=> ((st_q.mask & $past(wr_data)) == '0));

    a_r8_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_idx == IDX_STATUS) |=> ((st_q.stat & $past(st_q.stat)) == $past(st_q.stat)));

    a_r7_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.stat & $past(~st_q.kind & ~(pin_i ^ st_q.sense)))
                  == $past(~st_q.kind & ~(pin_i ^ st_q.sense))));

    a_r6_any_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.stat & $past(st_q.kind & st_q.both & (pin_i ^ st_q.prev)))
                  == $past(st_q.kind & st_q.both & (pin_i ^ st_q.prev))));

endmodule

// File: rtl/gpio_irq_bus.sv
module gpio_irq_bus
    import gpio_irq_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int W         = 32,
    parameter int BANK_AW   = 2
) (
    input  logic                   bus_wr,
    input  logic [BANK_AW+REG_IDX_W-1:0] bus_addr,
    input  logic [NUM_BANKS*W-1:0] kind_all,
    input  logic [NUM_BANKS*W-1:0] sense_all,
    input  logic [NUM_BANKS*W-1:0] both_all,
    input  logic [NUM_BANKS*W-1:0] mask_all,
    input  logic [NUM_BANKS*W-1:0] stat_all,
    output reg_idx_e               idx_o,
    output logic [NUM_BANKS-1:0]   bank_wr_o,
    output logic [W-1:0]           rdata_o
);

    logic [BANK_AW-1:0] bank_sel_w;

    assign bank_sel_w = bus_addr[BANK_AW+REG_IDX_W-1:REG_IDX_W];
    assign idx_o      = reg_idx_e'(bus_addr[REG_IDX_W-1:0]);

    always_comb begin
        bank_wr_o = '0;
        rdata_o   = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_sel_w == BANK_AW'(b)) begin
                bank_wr_o[b] = bus_wr;
                case (idx_o)
                    IDX_KIND:   rdata_o = kind_all[b*W +: W];
                    IDX_SENSE:  rdata_o = sense_all[b*W +: W];
                    IDX_BOTH:   rdata_o = both_all[b*W +: W];
                    IDX_MASK:   rdata_o = mask_all[b*W +: W];
                    IDX_STATUS: rdata_o = stat_all[b*W +: W];
                    default:    rdata_o = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/gpio_irq_top.sv
module gpio_irq_top
    import gpio_irq_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 32,
    parameter int BANK_AW   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_wr,
    input  logic [BANK_AW+2:0]          bus_addr,
    input  logic [BANK_W-1:0]           bus_wdata,
    output logic [BANK_W-1:0]           bus_rdata,
    input  logic [NUM_BANKS*BANK_W-1:0] pin_i,
    output logic                        irq_o
);

    localparam int TOTAL_W = NUM_BANKS * BANK_W;

    reg_idx_e             idx_w;
    logic [NUM_BANKS-1:0] bank_wr_w;
    logic [NUM_BANKS-1:0] pend_w;
    logic [TOTAL_W-1:0]   kind_all, sense_all, both_all, mask_all, stat_all;

    gpio_irq_bus #(
        .NUM_BANKS (NUM_BANKS),
        .W         (BANK_W),
        .BANK_AW   (BANK_AW)
    ) u_bus (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .kind_all  (kind_all),
        .sense_all (sense_all),
        .both_all  (both_all),
        .mask_all  (mask_all),
        .stat_all  (stat_all),
        .idx_o     (idx_w),
        .bank_wr_o (bank_wr_w),
        .rdata_o   (bus_rdata)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        gpio_irq_bank #(.W(BANK_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bank_wr_w[b]),
            .wr_idx  (idx_w),
            .wr_data (bus_wdata),
            .pin_i   (pin_i[b*BANK_W +: BANK_W]),
            .kind_o  (kind_all[b*BANK_W +: BANK_W]),
            .sense_o (sense_all[b*BANK_W +: BANK_W]),
            .both_o  (both_all[b*BANK_W +: BANK_W]),
            .mask_o  (mask_all[b*BANK_W +: BANK_W]),
            .stat_o  (stat_all[b*BANK_W +: BANK_W]),
            .pend_o  (pend_w[b])
        );
    end

    assign irq_o = |pend_w;

    a_r10_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_all) |-> !irq_o);

    a_r10_unmasked_status_fires: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_all & ~mask_all) != '0) |-> irq_o);

    a_r11_single_bank_write: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_wr_w));

endmodule

// File: tb/tb_gpio_irq_top.sv
`timescale 1ns/1ps
module tb_gpio_irq_top;

    localparam int NB = 2;
    localparam int W  = 8;
    localparam int AW = 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_wr = 1'b0;
    logic [AW+2:0]   bus_addr = '0;
    logic [W-1:0]    bus_wdata = '0;
    logic [W-1:0]    bus_rdata;
    logic [NB*W-1:0] pin_i = '0;
    logic            irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_irq_top #(.NUM_BANKS(NB), .BANK_W(W), .BANK_AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_i(pin_i), .irq_o(irq_o)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(int bank, int idx, logic [W-1:0] data);
        bus_addr  = (AW+3)'(bank * 8 + idx);
        bus_wdata = data;
        bus_wr    = 1'b1;
        tick();
        bus_wr    = 1'b0;
    endtask

    task automatic rd(int bank, int idx, output logic [W-1:0] data);
        bus_addr = (AW+3)'(bank * 8 + idx);
        #0.5;
        data = bus_rdata;
    endtask

    function automatic bit expect_hit(bit k, bit s, bit a, bit pv, bit cu);
        if (k) return (pv != cu) && (a || (s ? cu : pv));
        return (pv == s) || (cu == s);
    endfunction

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] v;
        repeat (3) @(negedge clk);
        // R1: reset values observed while reset is held
        for (int b = 0; b < NB; b++) begin
            rd(b, 5, v); check("R1 mask", v, 8'hFF);
            rd(b, 6, v); check("R1 status", v, 8'h00);
            rd(b, 0, v); check("R1 type", v, 8'h00);
            rd(b, 1, v); check("R1 polarity", v, 8'h00);
            rd(b, 2, v); check("R1 anyedge", v, 8'h00);
        end
        check("R1 irq", irq_o, 0);
        @(negedge clk);
        rst_n = 1'b1;
        tick();

        // R2: register read/write and bank isolation
        wr(0, 0, 8'hA5); wr(0, 1, 8'h3C); wr(0, 2, 8'h0F);
        wr(1, 0, 8'h5A);
        rd(0, 0, v); check("R2 type b0", v, 8'hA5);
        rd(0, 1, v); check("R2 pol b0", v, 8'h3C);
        rd(0, 2, v); check("R2 any b0", v, 8'h0F);
        rd(1, 0, v); check("R2 type b1", v, 8'h5A);
        rd(1, 1, v); check("R2 pol b1 untouched", v, 8'h00);

        // R11: write-only and reserved indexes read zero; out-of-range bank
        rd(0, 3, v); check("R11 enable reads 0", v, 0);
        rd(0, 4, v); check("R11 disable reads 0", v, 0);
        rd(0, 7, v); check("R11 reserved reads 0", v, 0);

        // R3/R4: mask updates
        wr(0, 3, 8'h0F); rd(0, 5, v); check("R3 enable clears", v, 8'hF0);
        wr(0, 3, 8'h00); rd(0, 5, v); check("R3 enable zero no effect", v, 8'hF0);
        wr(0, 5, 8'h00); rd(0, 5, v); check("R3 mask not writable", v, 8'hF0);
        wr(0, 4, 8'h01); rd(0, 5, v); check("R4 disable sets", v, 8'hF1);
        wr(0, 4, 8'h00); rd(0, 5, v); check("R4 disable zero no effect", v, 8'hF1);
        wr(0, 4, 8'hFF); rd(0, 5, v); check("R4 disable all", v, 8'hFF);
        rd(1, 5, v); check("R4 other bank mask", v, 8'hFF);

        // Sweep: every bank, pin, mode, transition (R5 R6 R7)
        for (int b = 0; b < NB; b++) begin
            for (int m = 0; m < 5; m++) begin
                bit k, s, a;
                case (m)
                    0: begin k = 1; s = 1; a = 0; end
                    1: begin k = 1; s = 0; a = 0; end
                    2: begin k = 1; s = 0; a = 1; end
                    3: begin k = 0; s = 1; a = 0; end
                    default: begin k = 0; s = 0; a = 1; end
                endcase
                wr(b, 0, {W{k}}); wr(b, 1, {W{s}}); wr(b, 2, {W{a}});
                for (int p = 0; p < W; p++) begin
                    for (int t = 0; t < 4; t++) begin
                        bit pv, cu, e;
                        pv = t[1]; cu = t[0];
                        pin_i = '0;
                        pin_i[b*W + p] = pv;
                        tick(); tick();
                        wr(b, 6, 8'hFF);
                        pin_i[b*W + p] = cu;
                        tick();
                        rd(b, 6, v);
                        e = expect_hit(k, s, a, pv, cu);
                        if (k && !a) check("R5 single edge", v[p], e);
                        else if (k) check("R6 any edge", v[p], e);
                        else check("R7 level", v[p], e);
                    end
                end
            end
        end

        // R7: level persists through a clear
        pin_i = '0;
        wr(0, 0, 8'h00); wr(0, 1, 8'hFF); wr(0, 2, 8'h00);
        pin_i[2] = 1'b1;
        tick();
        wr(0, 6, 8'hFF);
        rd(0, 6, v); check("R7 level holds after clear", v[2], 1);
        pin_i[2] = 1'b0;
        tick();
        wr(0, 6, 8'hFF);
        rd(0, 6, v); check("R7 clears once inactive", v, 8'h00);

        // Configure all banks rising edge, clear all
        for (int b = 0; b < NB; b++) begin
            wr(b, 0, 8'hFF); wr(b, 1, 8'hFF); wr(b, 2, 8'h00);
            wr(b, 4, 8'hFF);
        end
        pin_i = '0;
        tick();
        for (int b = 0; b < NB; b++) wr(b, 6, 8'hFF);

        // R8: partial W1C
        pin_i[1*W + 3] = 1'b1; pin_i[1*W + 5] = 1'b1;
        tick();
        rd(1, 6, v); check("R8 latched", v, 8'h28);
        wr(1, 6, 8'h00); rd(1, 6, v); check("R8 zero write keeps", v, 8'h28);
        wr(1, 6, 8'h08); rd(1, 6, v); check("R8 partial clear", v, 8'h20);

        // R9: latched while masked, fires on unmask
        check("R9 masked no irq", irq_o, 0);
        wr(1, 3, 8'h20);
        check("R9 irq after unmask", irq_o, 1);
        wr(1, 6, 8'h20);
        check("R10 irq drops on clear", irq_o, 0);

        // R10: other bank contributes
        wr(0, 3, 8'h01);
        check("R10 no event no irq", irq_o, 0);
        pin_i[0] = 1'b1;
        tick();
        check("R10 bank0 event irq", irq_o, 1);
        wr(0, 4, 8'h01);
        check("R10 remask drops irq", irq_o, 0);
        rd(0, 6, v); check("R10 status still latched", v[0], 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule